// File: doc/BRIEF.md
# Memory Protection Permission Checker

This combinational block makes the final allow/deny decision for a single memory access once the address-matching stage has run. The inputs are whether a protection entry matched, the 8-bit configuration of that entry, the kind of access (read, write or execute), whether the hart runs at machine privilege, and two policy bits. The first policy bit is lockdown. The second is deny-on-miss.

With lockdown clear, the conventional rules hold. Machine mode bypasses unlocked entries. All other accesses obey the entry's read, write and execute bits. With lockdown set, some combinations of the lock and permission bits change meaning and describe regions shared between machine and lower privilege. Every other encoding then applies to only one privilege level.

The block also settles accesses that no entry matched. A denied access drives exactly one of three fault lines, selected by the kind of access. The decision is routed through one of three paths: `PATH_MISS` (no entry matched), `PATH_LEGACY` (matched, lockdown clear) and `PATH_LOCKDOWN` (matched, lockdown set). Inside the lockdown path, the entry falls into one of four encoding classes: `ENC_SHR_EXEC`, `ENC_SHR_DATA`, `ENC_SHR_RO` and `ENC_PRIV_SPLIT`. There are no state transitions; the path and class are chosen anew from the inputs at every instant.

Top module: `pmp_perm_check`

## Requirements
- R1: The config byte holds read permission in bit 0, write in bit 1, execute in bit 2 and the lock flag in bit 7. With lockdown clear and an entry matched, a machine access is granted when lock is 0; when lock is 1, only the permission bit for the access kind decides.
- R2: With lockdown clear and an entry matched, a lower-privilege access is granted exactly when the permission bit for its kind is set, whatever the lock flag.
- R3: With lockdown set, a matched entry with lock=1, read=0, write=1 grants execute at both privileges. It grants read only to machine mode and only when execute=1. It never grants write.
- R4: With lockdown set, a matched entry with lock=0, read=0, write=1 grants read at both privileges. It grants write when the access is at machine privilege or execute=1. It never grants execute.
- R5: With lockdown set, a matched entry with lock, read, write and execute all 1 grants read at both privileges and denies write and execute.
- R6: With lockdown set, any other matched encoding applies only when the privilege agrees with the lock flag (machine with lock=1, lower with lock=0). It is then decided by the permission bits. On disagreement the access is denied.
- R7: With no entry matched, a lower-privilege access is always denied.
- R8: With no entry matched, a machine access is denied when deny-on-miss is set. Otherwise, if lockdown is set, only execute is denied. If neither bit is set, the access is granted.
- R9: Access code 00 is read, 01 is write, and 10 or 11 is execute. On a denial exactly one fault line is high: fetch for execute, load for read, store for write. When the access is granted, all three are low.
- R10: Config bits 3 to 6 (match mode and the reserved pair) have no effect on the decision.
- R11: Deny-on-miss has no effect when an entry matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| match_hit | input | 1 | An entry matched the access address |
| entry_cfg | input | 8 | Configuration byte of the matched entry |
| acc_kind | input | 2 | Access code: 00 read, 01 write, 1x execute |
| priv_mach | input | 1 | Access is at machine privilege |
| pol_lockdown | input | 1 | Lockdown policy bit |
| pol_deny_miss | input | 1 | Deny-on-miss policy bit |
| grant | output | 1 | Access permitted |
| fault_fetch | output | 1 | Instruction access fault |
| fault_load | output | 1 | Load access fault |
| fault_store | output | 1 | Store access fault |

## Verification
Two rules collide in the miss path when a machine access finds no entry while both policy bits are set. Deny-on-miss must then outrank the execute-only denial of lockdown, so reads and writes fault as well. A second overlap happens when a lockdown encoding that looks like a shared region also carries a lock flag that disagrees with the privilege. The shared-region meaning must win over the privilege-split rule. The bench provokes both overlaps with targeted vectors and then sweeps every combination of config byte, access code, privilege, policy bits and hit. It judges each result against a reference written straight from the requirements, which checks the grant and all three fault lines.

// File: rtl/pmp_perm_pkg.sv
package pmp_perm_pkg;

    localparam int CFG_W  = 8;
    localparam int ACC_W  = 2;
    localparam int N_FLT  = 3;

    typedef enum logic [ACC_W-1:0] {
        ACC_RD  = 2'b00,
        ACC_WR  = 2'b01,
        ACC_EX  = 2'b10,
        ACC_EX2 = 2'b11
    } acc_code_e;

    // one-hot view of the access kind; bit order matches fault lanes
    typedef struct packed {
        logic ex;
        logic wr;
        logic rd;
    } acc_sel_t;

    typedef struct packed {
        logic       lock;
        logic [1:0] rsv;
        logic [1:0] amode;
        logic       x;
        logic       w;
        logic       r;
    } cfg_t;

    typedef enum logic [1:0] {
        PATH_MISS     = 2'd0,
        PATH_LEGACY   = 2'd1,
        PATH_LOCKDOWN = 2'd2
    } path_e;

    typedef enum logic [1:0] {
        ENC_SHR_EXEC   = 2'd0,
        ENC_SHR_DATA   = 2'd1,
        ENC_SHR_RO     = 2'd2,
        ENC_PRIV_SPLIT = 2'd3
    } ld_enc_e;

endpackage

// File: rtl/pmp_acc_decode.sv
module pmp_acc_decode
    import pmp_perm_pkg::*;
(
    input  logic [ACC_W-1:0] code,
    output acc_sel_t         sel
);

    always_comb begin
        sel = '0;
        unique case (acc_code_e'(code))
            ACC_RD:          sel.rd = 1'b1;
            ACC_WR:          sel.wr = 1'b1;
            ACC_EX, ACC_EX2: sel.ex = 1'b1;
            default:         sel = '0;
        endcase
    end

endmodule

// File: rtl/pmp_legacy_rule.sv
module pmp_legacy_rule
    import pmp_perm_pkg::*;
(
    input  logic     lock,
    input  logic     perm_r,
    input  logic     perm_w,
    input  logic     perm_x,
    input  acc_sel_t sel,
    input  logic     priv_mach,
    output logic     ok
);

    logic bits_ok;

    always_comb begin
        bits_ok = (sel.rd & perm_r) | (sel.wr & perm_w) | (sel.ex & perm_x);
        if (priv_mach && !lock) begin
            ok = 1'b1;
        end else begin
            ok = bits_ok;
        end
    end

endmodule

// File: rtl/pmp_lockdown_rule.sv
module pmp_lockdown_rule
    import pmp_perm_pkg::*;
(
    input  logic     lock,
    input  logic     perm_r,
    input  logic     perm_w,
    input  logic     perm_x,
    input  acc_sel_t sel,
    input  logic     priv_mach,
    output logic     ok
);

    ld_enc_e enc;
    logic    bits_ok;

    always_comb begin
        if (lock && !perm_r && perm_w) begin
            enc = ENC_SHR_EXEC;
        end else if (!lock && !perm_r && perm_w) begin
            enc = ENC_SHR_DATA;
        end else if (lock && perm_r && perm_w && perm_x) begin
            enc = ENC_SHR_RO;
        end else begin
            enc = ENC_PRIV_SPLIT;
        end
    end

    always_comb begin
        bits_ok = (sel.rd & perm_r) | (sel.wr & perm_w) | (sel.ex & perm_x);
        unique case (enc)
            ENC_SHR_EXEC:   ok = sel.ex | (sel.rd & priv_mach & perm_x);
            ENC_SHR_DATA:   ok = sel.rd | (sel.wr & (priv_mach | perm_x));
            ENC_SHR_RO:     ok = sel.rd;
            ENC_PRIV_SPLIT: ok = (priv_mach == lock) ? bits_ok : 1'b0;
            default:        ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmp_miss_rule.sv
module pmp_miss_rule
    import pmp_perm_pkg::*;
(
    input  acc_sel_t sel,
    input  logic     priv_mach,
    input  logic     pol_lockdown,
    input  logic     pol_deny_miss,
    output logic     ok
);

    always_comb begin
        if (!priv_mach) begin
            ok = 1'b0;
        end else if (pol_deny_miss) begin
            ok = 1'b0;
        end else if (pol_lockdown) begin
            ok = ~sel.ex;
        end else begin
            ok = 1'b1;
        end
    end

endmodule

// File: rtl/pmp_perm_check.sv
module pmp_perm_check
    import pmp_perm_pkg::*;
(
    input  logic             match_hit,
    input  logic [CFG_W-1:0] entry_cfg,
    input  logic [ACC_W-1:0] acc_kind,
    input  logic             priv_mach,
    input  logic             pol_lockdown,
    input  logic             pol_deny_miss,
    output logic             grant,
    output logic             fault_fetch,
    output logic             fault_load,
    output logic             fault_store
);

    cfg_t             cfg;
    acc_sel_t         sel;
    path_e            path;
    logic             ok_legacy;
    logic             ok_lockdown;
    logic             ok_miss;
    logic [N_FLT-1:0] sel_vec;
    logic [N_FLT-1:0] fault_vec;
    logic             cfg_unused;

    assign cfg        = cfg_t'(entry_cfg);
    assign cfg_unused = ^{cfg.amode, cfg.rsv};

    pmp_acc_decode u_dec (
        .code (acc_kind),
        .sel  (sel)
    );

    pmp_legacy_rule u_legacy (
        .lock      (cfg.lock),
        .perm_r    (cfg.r),
        .perm_w    (cfg.w),
        .perm_x    (cfg.x),
        .sel       (sel),
        .priv_mach (priv_mach),
        .ok        (ok_legacy)
    );

    pmp_lockdown_rule u_lockdown (
        .lock      (cfg.lock),
        .perm_r    (cfg.r),
        .perm_w    (cfg.w),
        .perm_x    (cfg.x),
        .sel       (sel),
        .priv_mach (priv_mach),
        .ok        (ok_lockdown)
    );

    pmp_miss_rule u_miss (
        .sel           (sel),
        .priv_mach     (priv_mach),
        .pol_lockdown  (pol_lockdown),
        .pol_deny_miss (pol_deny_miss),
        .ok            (ok_miss)
    );

    always_comb begin
        if (!match_hit) begin
            path = PATH_MISS;
        end else if (pol_lockdown) begin
            path = PATH_LOCKDOWN;
        end else begin
            path = PATH_LEGACY;
        end
    end

    always_comb begin
        unique case (path)
            PATH_MISS:     grant = ok_miss;
            PATH_LEGACY:   grant = ok_legacy;
            PATH_LOCKDOWN: grant = ok_lockdown;
            default:       grant = 1'b0;
        endcase
    end

    assign sel_vec = sel;

    for (genvar i = 0; i < N_FLT; i++) begin : g_fault
        assign fault_vec[i] = ~grant & sel_vec[i];
    end

    assign fault_load  = fault_vec[0];
    assign fault_store = fault_vec[1];
    assign fault_fetch = fault_vec[2];

endmodule

// File: rtl/pmp_perm_check_sva.sv
module pmp_perm_check_sva (
    input logic       match_hit,
    input logic [7:0] entry_cfg,
    input logic [1:0] acc_kind,
    input logic       priv_mach,
    input logic       pol_lockdown,
    input logic       pol_deny_miss,
    input logic       grant,
    input logic       fault_fetch,
    input logic       fault_load,
    input logic       fault_store
);

    logic cfg_unused;
    assign cfg_unused = ^entry_cfg[6:3];

    always_comb begin
        // R9: a grant and a fault never coexist, and a denial raises one lane
        a_r9_one_fault: assert (grant ^ ($countones({fault_fetch, fault_load, fault_store}) == 1))
            else $error("grant/fault lanes inconsistent");
        // R9: the raised lane follows the access code
        a_r9_lane_kind: assert (!(fault_load && acc_kind != 2'b00) &&
                                !(fault_store && acc_kind != 2'b01) &&
                                !(fault_fetch && !acc_kind[1]))
            else $error("fault lane does not match access kind");
        // R7
        a_r7_miss_lower: assert (!(!match_hit && !priv_mach && grant))
            else $error("lower privilege granted on miss");
        // R8
        a_r8_deny_miss: assert (!(!match_hit && priv_mach && pol_deny_miss && grant))
            else $error("machine granted on miss under deny-on-miss");
        // R5
        a_r5_read_only: assert (!(match_hit && pol_lockdown && entry_cfg[7] &&
                                  entry_cfg[2:0] == 3'b111 && acc_kind != 2'b00 && grant))
            else $error("read-only shared region granted non-read");
        // R1
        a_r1_unlocked_mach: assert (!(match_hit && !pol_lockdown && priv_mach &&
                                      !entry_cfg[7] && !grant))
            else $error("unlocked entry denied machine access");
        // R3
        a_r3_shared_exec: assert (!(match_hit && pol_lockdown && entry_cfg[7] &&
                                    entry_cfg[1:0] == 2'b10 && acc_kind[1] && !grant))
            else $error("shared execute region denied execute");
        // R4
        a_r4_shared_data: assert (!(match_hit && pol_lockdown && !entry_cfg[7] &&
                                    entry_cfg[1:0] == 2'b10 && acc_kind[1] && grant))
            else $error("shared data region granted execute");
        // R11 touches pol_deny_miss only through the miss path
        a_r11_hit_indep: assert (!(match_hit && pol_deny_miss && !pol_lockdown &&
                                   priv_mach && !entry_cfg[7] && !grant))
            else $error("deny-on-miss affected a matched access");
    end

endmodule

bind pmp_perm_check pmp_perm_check_sva u_sva (
    .match_hit     (match_hit),
    .entry_cfg     (entry_cfg),
    .acc_kind      (acc_kind),
    .priv_mach     (priv_mach),
    .pol_lockdown  (pol_lockdown),
    .pol_deny_miss (pol_deny_miss),
    .grant         (grant),
    .fault_fetch   (fault_fetch),
    .fault_load    (fault_load),
    .fault_store   (fault_store)
);

// File: tb/pmp_perm_check_bench.sv
module pmp_perm_check_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       match_hit = 1'b0;
    logic [7:0] entry_cfg = 8'h00;
    logic [1:0] acc_kind = 2'b00;
    logic       priv_mach = 1'b0;
    logic       pol_lockdown = 1'b0;
    logic       pol_deny_miss = 1'b0;
    logic       grant;
    logic       fault_fetch;
    logic       fault_load;
    logic       fault_store;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp_ok;
        logic  [1:0] acc;
        string tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    pmp_perm_check u_pmp_perm_check (
        .match_hit     (match_hit),
        .entry_cfg     (entry_cfg),
        .acc_kind      (acc_kind),
        .priv_mach     (priv_mach),
        .pol_lockdown  (pol_lockdown),
        .pol_deny_miss (pol_deny_miss),
        .grant         (grant),
        .fault_fetch   (fault_fetch),
        .fault_load    (fault_load),
        .fault_store   (fault_store)
    );

    // reference decision built from the requirement text
    function automatic logic ref_ok(input logic [7:0] c, input logic [1:0] a,
                                    input logic pm, input logic ld,
                                    input logic wl, input logic hit);
        logic lk, pr, pw, px, rd, wr, ex, by_bits;
        lk = c[7]; px = c[2]; pw = c[1]; pr = c[0];
        ex = a[1]; wr = (a == 2'b01); rd = (a == 2'b00);
        by_bits = (rd && pr) || (wr && pw) || (ex && px);
        if (!hit) begin
            if (!pm) return 1'b0;
            if (wl)  return 1'b0;
            if (ld)  return !ex;
            return 1'b1;
        end
        if (!ld) begin
            if (pm && !lk) return 1'b1;
            return by_bits;
        end
        if (lk && !pr && pw)          return ex || (rd && pm && px);
        if (!lk && !pr && pw)         return rd || (wr && (pm || px));
        if (lk && pr && pw && px)     return rd;
        if (pm != lk)                 return 1'b0;
        return by_bits;
    endfunction

    function automatic string ref_tag(input logic [7:0] c, input logic pm,
                                      input logic ld, input logic hit);
        if (!hit) return pm ? "R8" : "R7";
        if (!ld)  return pm ? "R1" : "R2";
        if (c[7] && !c[0] && c[1])        return "R3";
        if (!c[7] && !c[0] && c[1])       return "R4";
        if (c[7] && c[0] && c[1] && c[2]) return "R5";
        return "R6";
    endfunction

    task automatic drive(input logic [7:0] c, input logic [1:0] a, input logic pm,
                         input logic ld, input logic wl, input logic hit,
                         input string tag);
        item_t it;
        @(posedge clk);
        #1;
        entry_cfg     = c;
        acc_kind      = a;
        priv_mach     = pm;
        pol_lockdown  = ld;
        pol_deny_miss = wl;
        match_hit     = hit;
        it.exp_ok = ref_ok(c, a, pm, ld, wl, hit);
        it.acc    = a;
        it.tag    = (tag == "") ? ref_tag(c, pm, ld, hit) : tag;
        sb_q.push_back(it);
    endtask

    // monitor: compares one item per cycle away from the driving edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [3:0] got, exp;
            it  = sb_q.pop_front();
            exp = {it.exp_ok,
                   !it.exp_ok && it.acc[1],
                   !it.exp_ok && (it.acc == 2'b00),
                   !it.exp_ok && (it.acc == 2'b01)};
            got = {grant, fault_fetch, fault_load, fault_store};
            checks++;
            if (got !== exp) begin
                failures++;
                $display("FAIL %s: {grant,fetch,load,store} actual=%b expected=%b",
                         it.tag, got, exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset state: idle inputs are a lower-privilege read with no match (R7)
        drive(8'h00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R7 reset");
        // R1 locked machine entry falls to bits
        drive(8'h81, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
        drive(8'h00, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
        // R2 lock flag irrelevant below machine
        drive(8'h84, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
        // R3 shared execute region, read needs machine and X
        drive(8'h86, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, "R3");
        drive(8'h86, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
        drive(8'h82, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
        // R4 shared data region
        drive(8'h02, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
        drive(8'h06, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
        // R5 read-only shared region
        drive(8'h87, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
        // R6 privilege/lock mismatch denied
        drive(8'h07, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
        // R8 both policy bits: deny-on-miss outranks execute-only
        drive(8'h00, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
        drive(8'h00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        drive(8'h00, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        // R9 access code 11 counts as execute
        drive(8'h00, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
        // R10 mode and reserved bits do not matter
        drive(8'h79, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
        drive(8'h7E, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
        // R11 deny-on-miss ignored on a match
        drive(8'h01, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, "R11");
        drive(8'h00, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, "R11");
        // full sweep against the reference
        for (int c = 0; c < 256; c++) begin
            for (int a = 0; a < 4; a++) begin
                for (int m = 0; m < 8; m++) begin
                    for (int h = 0; h < 2; h++) begin
                        drive(c[7:0], a[1:0], m[0], m[1], m[2], h[0], "");
                    end
                end
            end
        end
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule